// File: doc/BRIEF.md
# Input Gamma Lookup Table with Streaming Load

This block converts 8-bit RGB pixels into 12-bit unsigned fractional (u0.12) values through a table of 256 entries per channel. Software loads the table through a narrow port. It first writes a start index, then pushes colour words one after another into a single data input. The words fill the entry's red, green and blue fields in turn. After the blue word the index moves to the next entry by itself. A 3-bit channel mask decides which of those writes actually land in the table.

The pixel path has three sources. A mode bit picks between the table and a bypass path. The bypass path either left-aligns each 8-bit component into 12 bits, or passes it through a per-channel scale and bias stage. The table and the scale/bias stage can never be active together. Changing the prescale values drops the stage back to plain bypass, and enabling the stage moves the gamma mode to bypass.

Lookups are registered and take one cycle. A lookup of an entry that is being written in the same cycle returns the value the entry held before that write.

Top module: `input_gamma_lut`

## Requirements
- R1: After reset, out_vld_o is low and all three outputs are 0. The gamma mode is table (0), prescale bypass is on, every table entry is 0, the load index is 0 and the next word goes to red.
- R2: Each data_wr_i pulse stores data_i into the current entry. The first word after an index load goes to the red field (channel 0), the second to green (1) and the third to blue (2). After blue, the index advances by one and the next word goes to red again.
- R3: An idx_wr_i pulse loads idx_i and points the next word at red. If data_wr_i arrives in the same cycle, that data word is dropped and nothing is stored.
- R4: Each bit of wmask_i enables stores for one channel: bit 0 red, bit 1 green, bit 2 blue. A word aimed at a channel whose bit is clear is not stored, but the channel sequence and the index still advance.
- R5: The load index wraps from 255 to 0 after the blue word of entry 255.
- R6: In table mode, each output component equals the table field of its channel at the input component's value. The result appears one cycle after a cycle with pix_vld_i high, and out_vld_o is that cycle's pix_vld_i delayed by one. The outputs hold while pix_vld_i is low.
- R7: If a lookup and a stored word hit the same entry and channel in the same cycle, the lookup returns the old value. The new value is returned from the next cycle on.
- R8: In bypass mode (mode 1) with prescale bypass on, each output is the input component followed by four zero bits.
- R9: A pre_wr_i pulse writes pre_scale_i (unsigned, 12 fraction bits, reset value 1.0) and pre_bias_i (13-bit two's complement, reset value 0) for channel pre_ch_i (0 red, 1 green, 2 blue; code 3 stores nothing). It also always turns prescale bypass on.
- R10: A pre_en_i pulse without pre_wr_i turns prescale bypass off and sets the gamma mode to bypass. Each output then becomes the input component followed by four zero bits, multiplied by the channel's scale and shifted right by 12 bits. The channel's bias is added to that, and the result is clamped to the range 0..4095.
- R11: A mode_wr_i pulse sets the gamma mode to mode_i. Selecting table mode (0) also turns prescale bypass on. Priority in one cycle: pre_en_i is ignored when pre_wr_i is present, and mode_wr_i is ignored when an effective pre_en_i is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_wr_i | input | 1 | Load the table index |
| idx_i | input | 8 | Start index |
| data_wr_i | input | 1 | Push one colour word |
| data_i | input | 12 | Colour word, u0.12 |
| wmask_i | input | 3 | Channel store enables (bit 0 red, 1 green, 2 blue) |
| mode_wr_i | input | 1 | Write gamma mode |
| mode_i | input | 1 | 0 table, 1 bypass |
| pre_wr_i | input | 1 | Write scale and bias of one channel |
| pre_ch_i | input | 2 | Channel for pre_wr_i |
| pre_scale_i | input | 16 | Scale, 12 fraction bits |
| pre_bias_i | input | 13 | Bias, two's complement |
| pre_en_i | input | 1 | Enable the prescale stage |
| pix_vld_i | input | 1 | Pixel valid |
| pix_r_i | input | 8 | Red component |
| pix_g_i | input | 8 | Green component |
| pix_b_i | input | 8 | Blue component |
| out_vld_o | output | 1 | Result valid |
| out_r_o | output | 12 | Red result |
| out_g_o | output | 12 | Green result |
| out_b_o | output | 12 | Blue result |

## Verification
A pixel lookup and a streamed load word can fall in the same cycle on the same entry and channel. The bench points the load index at an entry and pushes a red word in the very cycle that a pixel with that red value is presented. It judges the result in two steps. That pixel's result must carry the entry's previous red value, and a second lookup of the same pixel on the next cycle must carry the new one. The same kind of collision is also used between idx_wr_i and data_wr_i, and between pre_wr_i, pre_en_i and mode_wr_i, where the stated priority decides the outcome.

// File: rtl/gl_pkg.sv
package gl_pkg;
  localparam int NUM_CH = 3;
  typedef enum logic [1:0] {
    CH_R = 2'd0,
    CH_G = 2'd1,
    CH_B = 2'd2
  } chan_e;
endpackage

// File: rtl/gl_loader.sv
module gl_loader
  import gl_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  idx_wr_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic                  data_wr_i,
  input  logic [NUM_CH-1:0]     wmask_i,
  output logic [IDX_W-1:0]      wr_idx_o,
  output logic [NUM_CH-1:0]     wr_en_o
);
  logic [IDX_W-1:0] idx_q;
  chan_e            ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ch_q  <= CH_R;
    end else if (idx_wr_i) begin
      idx_q <= idx_i;
      ch_q  <= CH_R;
    end else if (data_wr_i) begin
      if (ch_q == CH_B) begin
        ch_q  <= CH_R;
        idx_q <= idx_q + 1'b1;
      end else begin
        ch_q  <= chan_e'(ch_q + 2'd1);
      end
    end
  end

  assign wr_idx_o = idx_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_en
    // masked channel: sequence advances, store suppressed
    assign wr_en_o[c] = data_wr_i && !idx_wr_i && (ch_q == chan_e'(c)) && wmask_i[c];
  end

  assert_idx_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |=> (idx_q == $past(idx_i)) && (ch_q == CH_R));
  assert_idx_adv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !idx_wr_i && ch_q == CH_B) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));
  assert_ch_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_q != 2'd3);
  assert_one_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
endmodule

// File: rtl/gl_table.sv
module gl_table
  import gl_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_CH-1:0]                 wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  input  logic [NUM_CH-1:0][IDX_W-1:0]      rd_idx_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]     rd_data_o
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en_i[c]) begin
        mem[wr_idx_i] <= wr_data_i;
      end
    end

    // read sees pre-edge contents: old value on collision
    assign rd_data_o[c] = mem[rd_idx_i[c]];

    assert_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[c] |=> (mem[$past(wr_idx_i)] == $past(wr_data_i)));
  end
endmodule

// File: rtl/gl_prescale.sv
module gl_prescale
  import gl_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int DATA_W     = 12,
  parameter int SCALE_W    = 16,
  parameter int SCALE_FRAC = 12,
  parameter int BIAS_W     = 13
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              pre_wr_i,
  input  logic [1:0]                        pre_ch_i,
  input  logic [SCALE_W-1:0]                pre_scale_i,
  input  logic [BIAS_W-1:0]                 pre_bias_i,
  input  logic [NUM_CH-1:0][PIX_W-1:0]      pix_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]     res_o
);
  localparam int PROD_W = DATA_W + SCALE_W;
  localparam int SH_W   = PROD_W - SCALE_FRAC;
  localparam int SUM_W  = SH_W + 2;
  localparam int PAD_W  = DATA_W - PIX_W;
  localparam logic [DATA_W-1:0] MAX_V = '1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SCALE_W-1:0]      scale_q;
    logic [BIAS_W-1:0]       bias_q;
    logic [DATA_W-1:0]       x_al;
    logic [PROD_W-1:0]       prod;
    logic [SH_W-1:0]         prod_sh;
    logic signed [SUM_W-1:0] sum;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scale_q <= SCALE_W'(1) << SCALE_FRAC;
        bias_q  <= '0;
      end else if (pre_wr_i && pre_ch_i == 2'(c)) begin
        scale_q <= pre_scale_i;
        bias_q  <= pre_bias_i;
      end
    end

    always_comb begin
      x_al    = {pix_i[c], {PAD_W{1'b0}}};
      prod    = PROD_W'(x_al) * PROD_W'(scale_q);
      prod_sh = prod[PROD_W-1:SCALE_FRAC];
      sum     = $signed({2'b00, prod_sh})
              + $signed({{(SUM_W-BIAS_W){bias_q[BIAS_W-1]}}, bias_q});
      if (sum < 0)                              res_o[c] = '0;
      else if (sum > $signed(SUM_W'(MAX_V)))    res_o[c] = MAX_V;
      else                                      res_o[c] = sum[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/input_gamma_lut.sv
module input_gamma_lut
  import gl_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int DATA_W     = 12,
  parameter int SCALE_W    = 16,
  parameter int SCALE_FRAC = 12,
  parameter int BIAS_W     = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idx_wr_i,
  input  logic [PIX_W-1:0]   idx_i,
  input  logic               data_wr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [2:0]         wmask_i,
  input  logic               mode_wr_i,
  input  logic               mode_i,
  input  logic               pre_wr_i,
  input  logic [1:0]         pre_ch_i,
  input  logic [SCALE_W-1:0] pre_scale_i,
  input  logic [BIAS_W-1:0]  pre_bias_i,
  input  logic               pre_en_i,
  input  logic               pix_vld_i,
  input  logic [PIX_W-1:0]   pix_r_i,
  input  logic [PIX_W-1:0]   pix_g_i,
  input  logic [PIX_W-1:0]   pix_b_i,
  output logic               out_vld_o,
  output logic [DATA_W-1:0]  out_r_o,
  output logic [DATA_W-1:0]  out_g_o,
  output logic [DATA_W-1:0]  out_b_o
);
  localparam int IDX_W = PIX_W;
  localparam int PAD_W = DATA_W - PIX_W;

  logic [IDX_W-1:0]                  wr_idx;
  logic [NUM_CH-1:0]                 wr_en;
  logic [NUM_CH-1:0][PIX_W-1:0]      pix;
  logic [NUM_CH-1:0][DATA_W-1:0]     lut_rd, pre_res;
  logic [NUM_CH-1:0][DATA_W-1:0]     out_q;
  logic                              lut_byp_q, pre_byp_q, vld_q;
  logic                              pre_en_eff;

  assign pix        = {pix_b_i, pix_g_i, pix_r_i};
  assign pre_en_eff = pre_en_i && !pre_wr_i;

  gl_loader #(.IDX_W(IDX_W)) i_loader (
    .clk_i, .rst_ni, .idx_wr_i, .idx_i, .data_wr_i, .wmask_i,
    .wr_idx_o(wr_idx), .wr_en_o(wr_en)
  );

  gl_table #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_table (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(data_i),
    .rd_idx_i(pix), .rd_data_o(lut_rd)
  );

  gl_prescale #(
    .PIX_W(PIX_W), .DATA_W(DATA_W), .SCALE_W(SCALE_W),
    .SCALE_FRAC(SCALE_FRAC), .BIAS_W(BIAS_W)
  ) i_prescale (
    .clk_i, .rst_ni, .pre_wr_i, .pre_ch_i, .pre_scale_i, .pre_bias_i,
    .pix_i(pix), .res_o(pre_res)
  );

  // mode control: table and prescale never active together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lut_byp_q <= 1'b0;
      pre_byp_q <= 1'b1;
    end else if (pre_en_eff) begin
      lut_byp_q <= 1'b1;
      pre_byp_q <= 1'b0;
    end else begin
      if (pre_wr_i) pre_byp_q <= 1'b1;
      if (mode_wr_i) begin
        lut_byp_q <= mode_i;
        if (!mode_i) pre_byp_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= pix_vld_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    logic [DATA_W-1:0] sel;
    always_comb begin
      if (!lut_byp_q)     sel = lut_rd[c];
      else if (pre_byp_q) sel = {pix[c], {PAD_W{1'b0}}};
      else                sel = pre_res[c];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        out_q[c] <= '0;
      else if (pix_vld_i) out_q[c] <= sel;
    end
  end

  assign out_vld_o = vld_q;
  assign out_r_o   = out_q[0];
  assign out_g_o   = out_q[1];
  assign out_b_o   = out_q[2];

  assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_byp_q || pre_byp_q);
  assert_prewr_byp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_wr_i |=> pre_byp_q);
  assert_preen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_en_i && !pre_wr_i) |=> (lut_byp_q && !pre_byp_q));
  assert_vld_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_i |=> out_vld_o);
  assert_novld_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_i |=> (!out_vld_o && $stable(out_r_o) && $stable(out_g_o) && $stable(out_b_o)));
endmodule

// File: tb/test_input_gamma_lut.sv
module test_input_gamma_lut;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 0, data_wr = 0, mode_wr = 0, mode = 0;
  logic        pre_wr = 0, pre_en = 0, pix_vld = 0;
  logic [7:0]  idx = 0, pr = 0, pg = 0, pb = 0;
  logic [11:0] data = 0;
  logic [2:0]  wmask = 3'b111;
  logic [1:0]  pre_ch = 0;
  logic [15:0] pre_scale = 0;
  logic [12:0] pre_bias = 0;
  logic        out_vld;
  logic [11:0] out_r, out_g, out_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_lut [3][256];
  int m_idx, m_ch, m_lut_byp, m_pre_byp;
  int m_scale [3];
  int m_bias [3];

  always #10 clk = ~clk;

  input_gamma_lut i_input_gamma_lut (
    .clk_i(clk), .rst_ni(rst_n), .idx_wr_i(idx_wr), .idx_i(idx),
    .data_wr_i(data_wr), .data_i(data), .wmask_i(wmask),
    .mode_wr_i(mode_wr), .mode_i(mode), .pre_wr_i(pre_wr), .pre_ch_i(pre_ch),
    .pre_scale_i(pre_scale), .pre_bias_i(pre_bias), .pre_en_i(pre_en),
    .pix_vld_i(pix_vld), .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb),
    .out_vld_o(out_vld), .out_r_o(out_r), .out_g_o(out_g), .out_b_o(out_b)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expv(int c, int x);
    int v;
    if (m_lut_byp == 0) return m_lut[c][x];
    if (m_pre_byp != 0) return x << 4;
    v = (((x << 4) * m_scale[c]) >>> 12) + m_bias[c];
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic model_data(int d);
    if (wmask[m_ch]) m_lut[m_ch][m_idx] = d;
    m_ch++;
    if (m_ch == 3) begin m_ch = 0; m_idx = (m_idx + 1) % 256; end
  endtask

  task automatic set_idx(int i);
    idx = 8'(i); idx_wr = 1; m_idx = i; m_ch = 0;
    tick(); idx_wr = 0;
  endtask

  task automatic push(int d);
    data = 12'(d); data_wr = 1; model_data(d);
    tick(); data_wr = 0;
  endtask

  task automatic pix_chk(string req, int r, int g, int b);
    int er, eg, eb;
    er = expv(0, r); eg = expv(1, g); eb = expv(2, b);
    pr = 8'(r); pg = 8'(g); pb = 8'(b); pix_vld = 1;
    tick(); pix_vld = 0;
    chk({req, " vld"}, int'(out_vld), 1);
    chk({req, " red"}, int'(out_r), er);
    chk({req, " green"}, int'(out_g), eg);
    chk({req, " blue"}, int'(out_b), eb);
  endtask

  task automatic pre_write(int c, int s, int bias);
    pre_ch = 2'(c); pre_scale = 16'(s); pre_bias = 13'(bias); pre_wr = 1;
    if (c < 3) begin m_scale[c] = s; m_bias[c] = bias; end
    m_pre_byp = 1;
    tick(); pre_wr = 0;
  endtask

  task automatic pre_enable();
    pre_en = 1; m_pre_byp = 0; m_lut_byp = 1;
    tick(); pre_en = 0;
  endtask

  task automatic mode_write(int v);
    mode = v[0]; mode_wr = 1; m_lut_byp = v;
    if (v == 0) m_pre_byp = 1;
    tick(); mode_wr = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k, old_r;
    void'($urandom(32'd4711));
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < 256; i++) m_lut[c][i] = 0;
      m_scale[c] = 4096; m_bias[c] = 0;
    end
    m_idx = 0; m_ch = 0; m_lut_byp = 0; m_pre_byp = 1;
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    chk("R1 vld", int'(out_vld), 0);
    chk("R1 red", int'(out_r), 0);
    chk("R1 green", int'(out_g), 0);
    chk("R1 blue", int'(out_b), 0);
    rst_n = 1;
    tick();
    pix_chk("R1 table empty", 5, 77, 200);
    // R2: stream without index write starts at 0, red first
    push(12'h111); push(12'h222); push(12'h333); push(12'h444);
    pix_chk("R2 first entries", 0, 0, 0);
    pix_chk("R2 index advance", 1, 0, 0);
    // R2, R6: full random fill
    set_idx(0);
    for (int i = 0; i < 768; i++) push(int'($urandom_range(0, 4095)));
    for (int i = 0; i < 40; i++)
      pix_chk("R6 random lookup", int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    // R6: outputs hold with pix_vld low
    tick();
    chk("R6 vld low", int'(out_vld), 0);
    // R4: masked stores
    wmask = 3'b101; set_idx(40);
    push(12'hABC); push(12'hDEF); push(12'h123);
    pix_chk("R4 green masked", 40, 40, 40);
    wmask = 3'b010; push(12'h0F0); push(12'h0E0); push(12'h0D0);
    pix_chk("R4 only green at next", 41, 41, 41);
    wmask = 3'b111;
    // R5: index wrap
    set_idx(255);
    for (int i = 0; i < 6; i++) push(100 + i);
    pix_chk("R5 entry 255", 255, 255, 255);
    pix_chk("R5 wrapped to 0", 0, 0, 0);
    // R3: index write with concurrent data drops data
    data = 12'hFFF; data_wr = 1; idx = 8'd90; idx_wr = 1;
    m_idx = 90; m_ch = 0;
    tick(); data_wr = 0; idx_wr = 0;
    push(7); push(8); push(9);
    pix_chk("R3 coincident idx/data", 90, 90, 90);
    // R7: lookup collides with store to same entry/channel
    k = 123; set_idx(k);
    old_r = m_lut[0][k];
    pr = 8'(k); pg = 8'(k); pb = 8'(k); pix_vld = 1;
    data = 12'h5A5; data_wr = 1;
    tick(); pix_vld = 0; data_wr = 0;
    chk("R7 old value on collision", int'(out_r), old_r);
    model_data(12'h5A5);
    pix_chk("R7 new value next", k, k, k);
    // R8: bypass
    mode_write(1);
    for (int i = 0; i < 6; i++)
      pix_chk("R8 bypass", int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    pix_chk("R8 bypass corner", 0, 255, 128);
    // R9, R10: prescale
    pre_write(0, 8192, -100);
    pre_write(1, 2048, 50);
    pre_write(2, 65535, 0);
    pre_write(3, 1, 4000);
    pix_chk("R9 write keeps bypass", 10, 20, 30);
    pre_enable();
    pix_chk("R10 prescale", 200, 100, 255);
    pix_chk("R10 clamp low", 3, 0, 0);
    for (int i = 0; i < 8; i++) begin
      pre_write(i % 3, int'($urandom_range(0, 65535)), int'($urandom_range(0, 8191)) - 4096);
      pre_enable();
      pix_chk("R10 random prescale", int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    end
    pre_write(1, 4096, -4096);
    pix_chk("R9 write forces bypass", 60, 60, 60);
    // R11: enable ignored when coincident with a prescale write
    pre_ch = 2'd0; pre_scale = 16'd4096; pre_bias = 13'd0; pre_wr = 1; pre_en = 1;
    m_scale[0] = 4096; m_bias[0] = 0; m_pre_byp = 1;
    tick(); pre_wr = 0; pre_en = 0;
    pix_chk("R11 pre_wr beats pre_en", 33, 44, 55);
    pre_enable();
    pix_chk("R10 clamp after enable", 60, 60, 60);
    // R11: selecting table forces prescale bypass
    mode_write(0);
    pix_chk("R11 table after prescale", 40, 41, 255);
    mode_write(1);
    pix_chk("R11 prescale bypass stays on", 40, 41, 255);
    // R11: mode write ignored under effective enable
    mode = 1'b0; mode_wr = 1; pre_en = 1; m_pre_byp = 0; m_lut_byp = 1;
    tick(); mode_wr = 0; pre_en = 0;
    pix_chk("R11 pre_en beats mode_wr", 60, 60, 60);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule